// File: doc/BRIEF.md
# Serial-Controlled Differential Clock Enable Slave

This block is the two-wire control slave of a six-pair differential clock fanout device. It watches a two-wire serial bus (clock line and open-drain data line). It accepts block writes and block reads addressed to one fixed 7-bit slave address, and it keeps a small bank of byte registers. Two of those registers carry per-pair output enables. Each of the six true/complement pairs is copied from one reference clock when its enable is set, and is held low when the enable is clear.

A write transfer carries two leading bytes, a command byte and a count byte. The slave acknowledges both and then discards them. Every byte after those two lands in the register bank, starting at register 0 and rising by one per byte. A read transfer starts by returning a count byte that gives the number of register bytes, and then returns register 0, register 1 and so on in order. Register access is always sequential from the lowest index. The bus lines are oversampled by the system clock, so the transfer rate is set by the master (standard mode, 100 kbit/s, is the target). Enable changes are retimed into the reference clock domain, so that a pair starts and stops only on whole clock phases.

Top module: `smbfan_top`

## Requirements
- R1: Only the address byte 0xD2 (write) or 0xD3 (read), which is slave address 1101001 followed by the direction bit, is acknowledged. After any other address byte the slave leaves SDA released for the rest of the transfer, and the following bytes change no register.
- R2: In a write, the first two bytes after the address are acknowledged and discarded. Data byte n (n = 0, 1, ...) is stored in register n. The register contents appear on `regsOut`, with register k at bits [8k+7:8k].
- R3: Every byte of a write is acknowledged, including bytes beyond register 8. Bytes beyond register 8 change nothing.
- R4: In a read, the first byte returned is the count 0x09. Registers 0 to 8 follow in order, and any position past register 8 returns 0xFF. Bytes are sent MSB first.
- R5: When the master does not acknowledge a read byte, the slave stops driving SDA until the next START. Further clocked bits read as 1.
- R6: After reset, registers 0 to 5 and 8 are 0x00, register 6 is 0x8F, register 7 is 0xFF, and all six pairs are enabled.
- R7: The enables map to register bits as follows: pair 0 uses register 7 bit 0, pair 1 uses register 7 bit 2, pair 2 uses register 7 bit 4, pair 3 uses register 6 bit 0, pair 4 uses register 6 bit 1, and pair 5 uses register 6 bit 2. A value of 1 enables the pair. An enabled pair drives true equal to the reference clock and complement equal to its inverse.
- R8: A disabled pair holds both its true and complement outputs low.
- R9: Enabling or disabling a pair never yields a pulse shorter than one reference half period on either output.
- R10: A START or STOP at any point abandons the current transfer. A byte cut short by a STOP is not stored, and a repeated START begins a fresh address phase.
- R11: The slave changes its SDA drive only after a falling SCL edge, or on START or STOP.
- R12: Reserved bits of registers 6 and 7 are stored and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line |
| sdaIn | input | 1 | Serial data line as seen on the wire |
| sdaPullLow | output | 1 | 1 pulls the data line low (open drain) |
| refClk | input | 1 | Reference clock fanned out to the pairs |
| regsOut | output | 72 | Register bank, register k at bits [8k+7:8k] |
| pairTrue | output | 6 | True side of each differential pair |
| pairComp | output | 6 | Complement side of each differential pair |

## Verification
A wrong bit counter or state shows up within one byte time as a missing or misplaced acknowledge. It can also show up as a data byte landing in the wrong register on `regsOut`, or as a read stream shifted by one position, which the byte-by-byte readback compares catch. A wrong enable mapping or a gating error shows up within a few reference periods on the pair outputs. The sweep covers all 64 enable combinations and samples both phases of the reference clock. A pulse-width monitor on all twelve outputs catches runt pulses at the moment they end.

// File: rtl/smbfan_pkg.sv
`timescale 1ns/1ps
package smbfan_pkg;
  // width of the byte-position counter inside one transfer
  localparam int SEQ_W     = 5;
  localparam int NUM_PAIRS = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WRBYTE, ST_ACK, ST_RDBYTE, ST_RDACK, ST_DONE
  } busState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic             wrStb;
    logic             rdMode;
    logic [SEQ_W-1:0] seq;
    logic [7:0]       wrData;
  } strobe_t;
endpackage

// File: rtl/smbfan_ctrl.sv
`timescale 1ns/1ps
module smbfan_ctrl
  import smbfan_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output strobe_t    strb,
  output logic       sdaPullLow
);
  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t        state;
  logic [7:0]       shiftReg;
  logic [2:0]       bitCnt;
  logic             gotByte, rdMode, mAck, wrStb;
  logic [SEQ_W-1:0] seq, seqNext;

  assign seqNext = (seq == '1) ? seq : seq + SEQ_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      shiftReg <= '0;
      bitCnt   <= '0;
      gotByte  <= 1'b0;
      rdMode   <= 1'b0;
      seq      <= '0;
      mAck     <= 1'b0;
      wrStb    <= 1'b0;
    end else begin
      wrStb <= 1'b0;
      if (wrStb) seq <= seqNext;
      if (startDet) begin
        state   <= ST_ADDR;
        bitCnt  <= '0;
        gotByte <= 1'b0;
        seq     <= '0;
        rdMode  <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_ADDR, ST_WRBYTE: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[6:0], sdaS};
              bitCnt   <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) gotByte <= 1'b1;
            end else if (sclFall && gotByte) begin
              gotByte <= 1'b0;
              if (state == ST_ADDR) begin
                if (shiftReg[7:1] == SLAVE_ADDR) begin
                  rdMode <= shiftReg[0];
                  state  <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                wrStb <= 1'b1;
                state <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              if (rdMode) begin
                shiftReg <= rdData;
                seq      <= seqNext;
                bitCnt   <= '0;
                state    <= ST_RDBYTE;
              end else begin
                state <= ST_WRBYTE;
              end
            end
          end
          ST_RDBYTE: begin
            if (sclFall) begin
              if (bitCnt == 3'd7) begin
                bitCnt <= '0;
                state  <= ST_RDACK;
              end else begin
                shiftReg <= {shiftReg[6:0], 1'b1};
                bitCnt   <= bitCnt + 3'd1;
              end
            end
          end
          ST_RDACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                shiftReg <= rdData;
                seq      <= seqNext;
                state    <= ST_RDBYTE;
              end else begin
                state <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    sdaPullLow = (state == ST_ACK) || ((state == ST_RDBYTE) && !shiftReg[7]);
  end

  always_comb begin
    strb.wrStb  = wrStb;
    strb.rdMode = rdMode;
    strb.seq    = seq;
    strb.wrData = shiftReg;
  end

  // R11
  sda_grab_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> $past(sclFall));

  // R11
  sda_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> $past(sclFall || startDet || stopDet));

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |=> !strb.wrStb);
endmodule

// File: rtl/smbfan_regs.sv
`timescale 1ns/1ps
module smbfan_regs
  import smbfan_pkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  output logic [7:0]            rdData,
  output logic [NUM_REGS*8-1:0] regFlat,
  output logic [NUM_PAIRS-1:0]  pairEn
);
  localparam logic [7:0] COUNT_VAL = 8'(NUM_REGS);
  localparam int         EN_HI_REG = 6;
  localparam int         EN_LO_REG = 7;

  logic [SEQ_W-1:0] wrIdx, rdIdx;
  logic             wrOk;

  assign wrIdx = strb.seq - SEQ_W'(2);
  assign rdIdx = strb.seq - SEQ_W'(1);
  assign wrOk  = strb.wrStb && !strb.rdMode && (strb.seq >= SEQ_W'(2));

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [7:0] RST = (g == EN_HI_REG) ? 8'h8F :
                                 (g == EN_LO_REG) ? 8'hFF : 8'h00;
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              q <= RST;
      else if (wrOk && wrIdx == SEQ_W'(g))    q <= strb.wrData;
    end
    assign regFlat[g*8 +: 8] = q;
  end

  always_comb begin
    rdData = 8'hFF;
    if (strb.seq == '0) begin
      rdData = COUNT_VAL;
    end else begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (rdIdx == SEQ_W'(k)) rdData = regFlat[k*8 +: 8];
      end
    end
  end

  assign pairEn = {regFlat[EN_HI_REG*8 + 2], regFlat[EN_HI_REG*8 + 1],
                   regFlat[EN_HI_REG*8 + 0], regFlat[EN_LO_REG*8 + 4],
                   regFlat[EN_LO_REG*8 + 2], regFlat[EN_LO_REG*8 + 0]};

  // R10
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStb |=> $stable(regFlat));
endmodule

// File: rtl/smbfan_pairgate.sv
`timescale 1ns/1ps
module smbfan_pairgate
  import smbfan_pkg::*;
(
  input  logic                 refClk,
  input  logic                 rstN,
  input  logic [NUM_PAIRS-1:0] pairEn,
  output logic [NUM_PAIRS-1:0] pairTrue,
  output logic [NUM_PAIRS-1:0] pairComp
);
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : gPair
    logic enMeta, enT, enC;

    // true side: enable settles while refClk is low
    always_ff @(negedge refClk or negedge rstN) begin
      if (!rstN) begin
        enMeta <= 1'b1;
        enT    <= 1'b1;
      end else begin
        enMeta <= pairEn[g];
        enT    <= enMeta;
      end
    end

    // complement side: follows half a period later, while its output is low
    always_ff @(posedge refClk or negedge rstN) begin
      if (!rstN) enC <= 1'b1;
      else       enC <= enT;
    end

    assign pairTrue[g] = refClk & enT;
    assign pairComp[g] = ~refClk & enC;
  end
endmodule

// File: rtl/smbfan_top.sv
`timescale 1ns/1ps
module smbfan_top
  import smbfan_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         NUM_REGS   = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPullLow,
  input  logic                  refClk,
  output logic [NUM_REGS*8-1:0] regsOut,
  output logic [NUM_PAIRS-1:0]  pairTrue,
  output logic [NUM_PAIRS-1:0]  pairComp
);
  strobe_t               strb;
  logic [7:0]            rdData;
  logic [NUM_PAIRS-1:0]  pairEn;

  smbfan_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .strb(strb), .sdaPullLow(sdaPullLow)
  );

  smbfan_regs #(.NUM_REGS(NUM_REGS)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData),
    .regFlat(regsOut), .pairEn(pairEn)
  );

  smbfan_pairgate gate_i (
    .refClk(refClk), .rstN(rstN), .pairEn(pairEn),
    .pairTrue(pairTrue), .pairComp(pairComp)
  );
endmodule

// File: tb/smbfan_top_tb_top.sv
`timescale 1ns/1ps
module smbfan_top_tb_top;
  logic clk = 1'b0, refClk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaPull, sdaLine;
  logic [71:0] regsOut;
  logic [5:0]  pairT, pairC;

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #20 refClk = ~refClk;
  end

  assign sdaLine = sdaM & ~sdaPull;

  smbfan_top dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPull), .refClk(refClk), .regsOut(regsOut),
    .pairTrue(pairT), .pairComp(pairC)
  );

  int total = 0, bad = 0, runt = 0, ackCnt = 0;
  logic [7:0] model [9];
  logic [7:0] wbuf  [16];
  logic [7:0] rbuf  [16];

  // runt-pulse monitor on all twelve outputs (R9)
  time riseT [12];
  initial for (int i = 0; i < 12; i++) riseT[i] = 0;
  for (genvar g = 0; g < 6; g++) begin : gMon
    always @(posedge pairT[g]) riseT[g] = $time;
    always @(negedge pairT[g]) if (riseT[g] != 0 && $time - riseT[g] < 19) runt++;
    always @(posedge pairC[g]) riseT[g+6] = $time;
    always @(negedge pairC[g]) if (riseT[g+6] != 0 && $time - riseT[g+6] < 19) runt++;
  end

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; q(); sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0; q();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; q(); sclM = 1'b1; q(); sdaM = 1'b1; q();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ackd);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; q(); sclM = 1'b1; q(); sclM = 1'b0; q();
    end
    sdaM = 1'b1; q(); sclM = 1'b1; q(); ackd = !sdaLine; sclM = 1'b0; q();
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); sclM = 1'b1; q(); b[i] = sdaLine; sclM = 1'b0;
    end
    q(); sdaM = giveAck ? 1'b0 : 1'b1; q(); sclM = 1'b1; q(); sclM = 1'b0; q();
    sdaM = 1'b1;
  endtask

  task automatic busWrite(input int n);
    bit a;
    ackCnt = 0;
    i2cStart();
    sendByte(8'hD2, a); ackCnt += int'(a);
    sendByte(8'h5C, a); ackCnt += int'(a);
    sendByte(8'h33, a); ackCnt += int'(a);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], a); ackCnt += int'(a);
      if (i < 9) model[i] = wbuf[i];
    end
    i2cStop();
  endtask

  task automatic busRead(input int n);
    bit a;
    i2cStart();
    sendByte(8'hD3, a);
    ackCnt = int'(a);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rbuf[i]);
    i2cStop();
  endtask

  function automatic logic [71:0] packModel();
    logic [71:0] v;
    for (int k = 0; k < 9; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  // enable map from R7: pair0 r7.0, pair1 r7.2, pair2 r7.4, pair3..5 r6.0..2
  function automatic logic [5:0] enOf(input logic [7:0] r6, input logic [7:0] r7);
    return {r6[2], r6[1], r6[0], r7[4], r7[2], r7[0]};
  endfunction

  task automatic checkPairs(input string tag, input logic [5:0] en);
    logic [5:0] t1, c1, t2, c2;
    @(posedge refClk); #5; t1 = pairT; c1 = pairC;
    @(negedge refClk); #5; t2 = pairT; c2 = pairC;
    chk(tag, {t1, c1, t2, c2}, {en, 6'b0, 6'b0, en});
  endtask

  task automatic settle();
    repeat (4) @(posedge refClk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] b;
    for (int k = 0; k < 9; k++) model[k] = 8'h00;
    model[6] = 8'h8F; model[7] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R6 reset values and all pairs enabled
    chk("R6 reset registers", regsOut, packModel());
    chk("R6 sda released at reset", {71'b0, sdaPull}, 72'b0);
    checkPairs("R6 R7 pairs enabled after reset", 6'h3F);

    // R1 foreign addresses: no ack, trailing bytes ignored
    i2cStart(); sendByte(8'hA4, a);
    chk("R1 foreign address not acked", {71'b0, a}, 72'b0);
    sendByte(8'h00, a); sendByte(8'h00, a);
    chk("R1 trailing byte not acked", {71'b0, a}, 72'b0);
    sendByte(8'h00, a);
    i2cStop();
    i2cStart(); sendByte(8'hD0, a);
    chk("R1 neighbour address not acked", {71'b0, a}, 72'b0);
    sendByte(8'h11, a); sendByte(8'h22, a); sendByte(8'h33, a);
    i2cStop();
    chk("R1 registers untouched", regsOut, packModel());

    // R2 R3 full write including two bytes past register 8
    for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'h10 + i * 8'h13);
    wbuf[6] = 8'hF7; wbuf[7] = 8'hBD;
    wbuf[9] = 8'h77; wbuf[10] = 8'h66;
    busWrite(11);
    chk("R3 every write byte acked", 72'(ackCnt), 72'd14);
    chk("R2 R3 data stored in order", regsOut, packModel());

    // R4 read back count, registers, then past end
    busRead(12);
    chk("R1 read address acked", 72'(ackCnt), 72'd1);
    chk("R4 count byte", 72'(rbuf[0]), 72'h09);
    for (int i = 0; i < 9; i++) chk($sformatf("R4 read reg%0d", i), 72'(rbuf[i+1]), 72'(model[i]));
    chk("R4 past end reads FF", 72'({rbuf[10], rbuf[11]}), 72'hFFFF);

    // R5 nack stops slave output
    i2cStart(); sendByte(8'hD3, a);
    recvByte(1'b1, b); recvByte(1'b0, b);
    chk("R5 byte before nack", 72'(b), 72'(model[0]));
    recvByte(1'b0, b);
    chk("R5 released after nack", 72'(b), 72'hFF);
    i2cStop();

    // R10 stop in the middle of a byte
    i2cStart(); sendByte(8'hD2, a); sendByte(8'h01, a); sendByte(8'h09, a);
    sendByte(8'hC3, a); model[0] = 8'hC3;
    for (int i = 7; i >= 4; i--) begin
      sdaM = 1'(8'h5A >> i); q(); sclM = 1'b1; q(); sclM = 1'b0; q();
    end
    i2cStop();
    chk("R10 partial byte dropped", regsOut, packModel());

    // R10 repeated start switches to a read
    i2cStart(); sendByte(8'hD2, a); sendByte(8'h01, a);
    i2cStart(); sendByte(8'hD3, a);
    chk("R10 repeated start address acked", {71'b0, a}, 72'd1);
    recvByte(1'b1, b);
    chk("R10 count after repeated start", 72'(b), 72'h09);
    recvByte(1'b0, b);
    chk("R10 reg0 after repeated start", 72'(b), 72'(model[0]));
    i2cStop();

    // R7 R8 R12 sweep over all enable combinations
    for (int c = 0; c < 64; c++) begin
      logic [5:0] cv;
      cv = 6'(c);
      for (int k = 0; k < 6; k++) wbuf[k] = 8'(c * 7 + k * 29);
      wbuf[6] = {cv[4:0], cv[5:3]};
      wbuf[7] = {cv[5], cv[4], cv[3], cv[2], ~cv[0], cv[1], ~cv[1], cv[0]};
      busWrite(8);
      chk($sformatf("R12 R2 regs combo %0d", c), regsOut, packModel());
      settle();
      checkPairs($sformatf("R7 R8 pairs combo %0d", c), enOf(model[6], model[7]));
      if (c % 16 == 5) begin
        busRead(9);
        chk($sformatf("R12 readback r6 r7 combo %0d", c),
            72'({rbuf[7], rbuf[8]}), 72'({model[6], model[7]}));
      end
    end

    chk("R9 no runt pulses", 72'(runt), 72'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule